// File: doc/BRIEF.md
# Pin Change Interrupt Unit

This block watches a set of input pins and raises a sticky interrupt whenever an enabled pin changes level. Each pin has two configuration bits: one that enables it as an interrupt source, and one that requests a weak pull-up. Software reaches these bits through a small word-wide register port. Because there are more pins than bits in a data word, each bit set is split into a low half and a high half.

While the processor is awake, the unit first passes the pins through a synchronizer. It then compares each synchronized sample with the one taken a clock earlier. Before sleep, it keeps a copy of the synchronized levels. While the sleep input is high, it compares the raw pins with that copy using combinational logic. This lets it drive a wake request even when no clock edge arrives. Each pull-up request reaches the pad only while that pin's direction input marks it as an input.

Top module: `chg_notify`

## Requirements
- R1: After reset, every enable bit and pull-up bit is 0, the interrupt output is low, and every pull-up output is low.
- R2: A write stores data bits into the configuration registers, and a read returns them. Address 0 holds the enable bits of pins 0..15, and address 1 holds the enable bits of pins 16..21 in data bits 5:0. Address 2 holds the pull-up bits of pins 0..15, and address 3 holds the pull-up bits of pins 16..21 in data bits 5:0. Data bit k of a low register belongs to pin k, and data bit k of a high register belongs to pin 16+k. The unused upper data bits read as 0.
- R3: A level change on an enabled pin sets the interrupt output after exactly three rising clock edges. The pin is driven between edges, and the interrupt output is high after the third edge.
- R4: A level change on a pin whose enable bit is 0 never sets the interrupt output.
- R5: The interrupt output stays high until a write to address 4 with data bit 0 equal to 1. A write to address 4 with bit 0 equal to 0 leaves it set.
- R6: If an enabled change is detected on the same edge as a clear write, the interrupt output stays high.
- R7: Each pull-up output equals that pin's pull-up bit AND its direction input, where 1 means input.
- R8: The wake output is low while the sleep input is low. While the sleep input is high, the wake output is high exactly when the interrupt output is high or an enabled raw pin differs from the level captured on the last clock edge before sleep.
- R9: With the sleep input high and the clock stopped, a change on an enabled pin raises the wake output with no clock edge. When the clock resumes, the same change sets the interrupt output.
- R10: A read of address 4 returns the interrupt state in data bit 0, with all other data bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; may be stopped during sleep |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 22 | Monitored pin levels |
| pin_is_input | input | 22 | Per-pin direction, 1 = input |
| sleep_req | input | 1 | High while the processor sleeps |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0..4) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq_o | output | 1 | Sticky interrupt request |
| wake_o | output | 1 | Asynchronous wake request |
| pullup_o | output | 22 | Effective per-pin pull-up request |

## Verification
The assertions check four things on every clock edge:
- no pull-up output is high for a pin marked as an output;
- wake is low outside sleep and high during sleep whenever the interrupt is pending;
- the interrupt holds unless a clear write arrives;
- the status read mirrors the interrupt.

Three behaviours can only be shown by the bench's scenarios, because they depend on pin history and register contents that no port exposes:
- the exact three-edge detection latency;
- the masking of disabled pins;
- the priority of a change over a same-edge clear.

The asynchronous wake while the clock is stopped also needs a scenario, since no clocked check can see it.

// File: rtl/cn_pkg.sv
package cn_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      CN_EN_LO = 3'd0,
      CN_EN_HI = 3'd1,
      CN_PU_LO = 3'd2,
      CN_PU_HI = 3'd3,
      CN_STAT  = 3'd4
   } cn_addr_e;

   // status word bit that carries the interrupt flag / clear command
   localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/cn_regs.sv
module cn_regs
   import cn_pkg::*;
#(
   parameter int NUM_PINS = 22,
   parameter int WORD_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [WORD_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] en_q,
   output logic [NUM_PINS-1:0] pu_q,
   output logic [WORD_W-1:0]   cfg_rdata
);
   // merge a word into the low or high slice of a per-pin vector
   function automatic logic [NUM_PINS-1:0] merge_half(
      input logic [NUM_PINS-1:0] cur,
      input logic [WORD_W-1:0]   d,
      input logic                hi);
      logic [NUM_PINS-1:0] r;
      r = cur;
      for (int i = 0; i < NUM_PINS; i++) begin
         if ((i >= WORD_W) == hi) begin
            r[i] = d[hi ? (i - WORD_W) : i];
         end
      end
      return r;
   endfunction

   // extract the low or high slice of a per-pin vector as a word
   function automatic logic [WORD_W-1:0] slice_half(
      input logic [NUM_PINS-1:0] v,
      input logic                hi);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int j = 0; j < WORD_W; j++) begin
         if (hi) begin
            if (j + WORD_W < NUM_PINS) r[j] = v[j + WORD_W];
         end else begin
            if (j < NUM_PINS) r[j] = v[j];
         end
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         pu_q <= '0;
      end else if (we) begin
         case (addr)
            CN_EN_LO: en_q <= merge_half(en_q, wdata, 1'b0);
            CN_EN_HI: en_q <= merge_half(en_q, wdata, 1'b1);
            CN_PU_LO: pu_q <= merge_half(pu_q, wdata, 1'b0);
            CN_PU_HI: pu_q <= merge_half(pu_q, wdata, 1'b1);
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         CN_EN_LO: cfg_rdata = slice_half(en_q, 1'b0);
         CN_EN_HI: cfg_rdata = slice_half(en_q, 1'b1);
         CN_PU_LO: cfg_rdata = slice_half(pu_q, 1'b0);
         CN_PU_HI: cfg_rdata = slice_half(pu_q, 1'b1);
         default:  cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cn_sync.sv
module cn_sync #(
   parameter int WIDTH  = 22,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cn_detect.sv
module cn_detect #(
   parameter int NUM_PINS = 22,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_raw,
   input  logic [NUM_PINS-1:0] pins_sync,
   input  logic [NUM_PINS-1:0] en,
   input  logic                sleep,
   input  logic                clr,
   output logic                flag,
   output logic                wake
);
   localparam int WARM_W = STAGES + 1;

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] snap_q;
   logic [WARM_W-1:0]   warm_q;
   logic                primed;
   logic                change;
   logic                async_diff;

   // ignore comparisons until synchronizer and history hold real samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm_q <= '0;
      else        warm_q <= {warm_q[WARM_W-2:0], 1'b1};
   end
   assign primed = warm_q[WARM_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins_sync;
   end

   // snapshot follows the synchronized pins while awake, freezes in sleep
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap_q <= '0;
      else if (!sleep) snap_q <= pins_sync;
   end

   assign change = primed && ((en & (pins_sync ^ prev_q)) != '0);

   // change wins over a same-edge clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag && !clr) || change;
   end

   assign async_diff = (en & (pins_raw ^ snap_q)) != '0;
   assign wake       = sleep && (flag || async_diff);
endmodule

// File: rtl/chg_notify.sv
module chg_notify
   import cn_pkg::*;
#(
   parameter int NUM_PINS    = 22,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] pin_is_input,
   input  logic                sleep_req,
   input  logic                reg_we,
   input  logic [2:0]          reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic                irq_o,
   output logic                wake_o,
   output logic [NUM_PINS-1:0] pullup_o
);
   if (NUM_PINS < 1 || NUM_PINS > 2 * WORD_W) begin : g_bad_pins
      $error("chg_notify: NUM_PINS must lie in 1..2*WORD_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("chg_notify: SYNC_STAGES must be at least 2");
   end
   if (WORD_W <= STAT_FLAG_BIT) begin : g_bad_word
      $error("chg_notify: WORD_W too narrow for status word");
   end

   logic [NUM_PINS-1:0] en_q;
   logic [NUM_PINS-1:0] pu_q;
   logic [NUM_PINS-1:0] pins_sync;
   logic [WORD_W-1:0]   cfg_rdata;
   logic                clr;
   logic                flag;

   assign clr = reg_we && (reg_addr == CN_STAT) && reg_wdata[STAT_FLAG_BIT];

   cn_regs #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .en_q      (en_q),
      .pu_q      (pu_q),
      .cfg_rdata (cfg_rdata)
   );

   cn_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_sync)
   );

   cn_detect #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_raw  (pin_in),
      .pins_sync (pins_sync),
      .en        (en_q),
      .sleep     (sleep_req),
      .clr       (clr),
      .flag      (flag),
      .wake      (wake_o)
   );

   assign irq_o    = flag;
   assign pullup_o = pu_q & pin_is_input;

   always_comb begin
      if (reg_addr == CN_STAT) begin
         reg_rdata = '0;
         reg_rdata[STAT_FLAG_BIT] = flag;
      end else begin
         reg_rdata = cfg_rdata;
      end
   end
endmodule

// File: rtl/chg_notify_chk.sv
module chg_notify_chk #(
   parameter int NUM_PINS = 22,
   parameter int WORD_W   = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_is_input,
   input logic                sleep_req,
   input logic                reg_we,
   input logic [2:0]          reg_addr,
   input logic [WORD_W-1:0]   reg_wdata,
   input logic [WORD_W-1:0]   reg_rdata,
   input logic                irq_o,
   input logic                wake_o,
   input logic [NUM_PINS-1:0] pullup_o
);
   AST_PULLUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (pullup_o & ~pin_is_input) == '0); // R7

   AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_req |-> !wake_o); // R8

   AST_WAKE_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && irq_o) |-> wake_o); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(reg_we && reg_addr == 3'd4 && reg_wdata[0])) |=> irq_o); // R5

   AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd4) |-> (reg_rdata == {{(WORD_W-1){1'b0}}, irq_o})); // R10
endmodule

bind chg_notify chg_notify_chk #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pin_is_input (pin_is_input),
   .sleep_req    (sleep_req),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .irq_o        (irq_o),
   .wake_o       (wake_o),
   .pullup_o     (pullup_o)
);

// File: tb/chg_notify_tb.sv
module chg_notify_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 22;
   localparam int W  = 16;
   localparam int ST = 2;

   logic          clk_free = 1'b0;
   logic          gate = 1'b1;
   logic          clk;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_is_input = '1;
   logic          sleep_req = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [W-1:0]  reg_wdata = '0;
   logic [W-1:0]  reg_rdata;
   logic          irq_o, wake_o;
   logic [N-1:0]  pullup_o;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk_free = ~clk_free;
   assign clk = clk_free & gate;

   chg_notify u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_is_input(pin_is_input),
      .sleep_req(sleep_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
      .wake_o(wake_o), .pullup_o(pullup_o)
   );

   // ---------------- behavioural reference model ----------------
   logic [N-1:0] hist [$];
   logic [N-1:0] m_en = '0, m_pu = '0, m_snap = '0;
   logic         m_flag = 1'b0;
   int           m_edges = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i <= ST; i++) hist.push_back('0);
         m_en = '0; m_pu = '0; m_snap = '0; m_flag = 1'b0; m_edges = 0;
      end else begin
         logic [N-1:0] newest, older;
         logic chg, clr;
         newest = hist[hist.size()-ST];
         older  = hist[hist.size()-ST-1];
         chg = (m_edges >= ST + 1) && ((m_en & (newest ^ older)) != '0);
         clr = reg_we && reg_addr == 3'd4 && reg_wdata[0];
         if (!sleep_req) m_snap = newest;
         hist.push_back(pin_in);
         if (hist.size() > ST + 2) void'(hist.pop_front());
         if (reg_we) begin
            case (reg_addr)
               3'd0: m_en[15:0]  = reg_wdata;
               3'd1: m_en[21:16] = reg_wdata[5:0];
               3'd2: m_pu[15:0]  = reg_wdata;
               3'd3: m_pu[21:16] = reg_wdata[5:0];
               default: ;
            endcase
         end
         m_flag = (m_flag && !clr) || chg;
         m_edges++;
      end
   end

   function automatic logic [W-1:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_en[15:0];
         3'd1: return {10'd0, m_en[21:16]};
         3'd2: return m_pu[15:0];
         3'd3: return {10'd0, m_pu[21:16]};
         3'd4: return {15'd0, m_flag};
         default: return '0;
      endcase
   endfunction

   function automatic logic model_wake();
      return sleep_req && (m_flag || ((m_en & (pin_in ^ m_snap)) != '0));
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, "irq_o", 32'(irq_o), 32'(m_flag));
         check("R7", "pullup_o", 32'(pullup_o), 32'(m_pu & pin_is_input));
         check("R8", "wake_o", 32'(wake_o), 32'(model_wake()));
         check("R2", "reg_rdata", 32'(reg_rdata), 32'(model_read(reg_addr)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [W-1:0] exp);
      reg_addr = a;
      #1;
      check(req, "read", 32'(reg_rdata), 32'(exp));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk_free);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);

      // R1 reset state
      cur_req = "R1";
      check("R1", "irq after reset", 32'(irq_o), 0);
      check("R1", "pullup after reset", 32'(pullup_o), 0);
      rd_check("R1", 3'd0, 16'h0);
      rd_check("R1", 3'd3, 16'h0);
      cycles(4);

      // R2 register layout
      cur_req = "R2";
      wr(3'd0, 16'hA5C3);
      wr(3'd1, 16'hFFEA);      // only bits 5:0 kept
      wr(3'd2, 16'h00F0);
      wr(3'd3, 16'hFF31);
      rd_check("R2", 3'd0, 16'hA5C3);
      rd_check("R2", 3'd1, 16'h002A);
      rd_check("R2", 3'd2, 16'h00F0);
      rd_check("R2", 3'd3, 16'h0031);

      // R7 pull-up gating by direction
      cur_req = "R7";
      pin_is_input = 22'h3F_FF0F;
      #1 check("R7", "pullup mix", 32'(pullup_o), 32'(22'h31_00F0 & 22'h3F_FF0F));
      pin_is_input = '0;
      #1 check("R7", "pullup all outputs", 32'(pullup_o), 0);
      pin_is_input = '1;
      cycles(2);

      // R3 enabled change: pin 0 enabled (bit 0 of 0xA5C3 = 1)
      cur_req = "R3";
      pin_in[0] = 1'b1;
      cycles(2);
      check("R3", "irq before third edge", 32'(irq_o), 0);
      cycles(1);
      check("R3", "irq after third edge", 32'(irq_o), 1);
      // high pin 17 enabled (0x2A bit 1)
      cur_req = "R5";
      wr(3'd4, 16'h0001);
      check("R5", "irq cleared", 32'(irq_o), 0);
      cur_req = "R3";
      pin_in[17] = 1'b1;
      cycles(3);
      check("R3", "irq from high pin", 32'(irq_o), 1);

      // R5 write of 0 does not clear
      cur_req = "R5";
      wr(3'd4, 16'h0000);
      check("R5", "irq kept after zero write", 32'(irq_o), 1);
      rd_check("R10", 3'd4, 16'h0001);
      wr(3'd4, 16'h0001);
      check("R5", "irq cleared by one", 32'(irq_o), 0);
      rd_check("R10", 3'd4, 16'h0000);

      // R4 disabled pins: pin 2 (0xA5C3 bit2=0), pin 16 (0x2A bit0=0)
      cur_req = "R4";
      pin_in[2] = 1'b1; pin_in[16] = 1'b1;
      cycles(6);
      check("R4", "disabled change ignored", 32'(irq_o), 0);
      pin_in[2] = 1'b0;
      cycles(6);
      check("R4", "disabled change ignored again", 32'(irq_o), 0);

      // R6 change coinciding with clear
      cur_req = "R6";
      pin_in[1] = 1'b1;                 // enabled (bit1 of 0xA5C3)
      cycles(4);
      check("R6", "flag set before race", 32'(irq_o), 1);
      pin_in[1] = 1'b0;
      cycles(2);
      wr(3'd4, 16'h0001);               // clear lands on the detecting edge
      check("R6", "change beats clear", 32'(irq_o), 1);
      wr(3'd4, 16'h0001);
      check("R6", "plain clear afterwards", 32'(irq_o), 0);

      // R8 sleep with running clock
      cur_req = "R8";
      cycles(4);
      sleep_req = 1'b1;
      #1 check("R8", "wake idle in sleep", 32'(wake_o), 0);
      pin_in[0] = 1'b0;                 // enabled pin moves
      #1 check("R8", "wake on enabled diff", 32'(wake_o), 1);
      cycles(4);
      check("R8", "flag set in sleep", 32'(irq_o), 1);
      sleep_req = 1'b0;
      #1 check("R8", "wake low when awake", 32'(wake_o), 0);
      wr(3'd4, 16'h0001);
      cycles(4);

      // R9 clock stopped
      cur_req = "R9";
      sleep_req = 1'b1;
      gate = 1'b0;
      #(3*CLK_PERIOD);
      check("R9", "wake quiet, stopped clock", 32'(wake_o), 0);
      pin_in[2] = 1'b0; pin_in[16] = 1'b0; // disabled pins
      #CLK_PERIOD;
      check("R9", "disabled pins no wake", 32'(wake_o), 0);
      pin_in[3] = 1'b1;                 // wait: bit3 of 0xA5C3 = 0 -> disabled
      #CLK_PERIOD;
      check("R9", "pin 3 disabled no wake", 32'(wake_o), 0);
      pin_in[6] = 1'b1;                 // bit6 of 0xA5C3 = 1
      #CLK_PERIOD;
      check("R9", "wake without clock", 32'(wake_o), 1);
      pin_in[6] = 1'b0;
      #CLK_PERIOD;
      check("R9", "wake drops when level returns", 32'(wake_o), 0);
      pin_in[6] = 1'b1;
      #CLK_PERIOD;
      check("R9", "wake again", 32'(wake_o), 1);
      @(negedge clk_free);
      gate = 1'b1;
      cycles(3);
      check("R9", "flag after clock resumes", 32'(irq_o), 1);
      check("R9", "wake held by flag", 32'(wake_o), 1);
      sleep_req = 1'b0;
      wr(3'd4, 16'h0001);
      cycles(3);
      check("R5", "final clear", 32'(irq_o), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule